// File: doc/BRIEF.md
# Inter-Packet Gap Monitor

This block sits next to a serial packet transmitter and confirms that the transmitter leaves enough idle time between packets. It listens passively to the register writes the transmitter receives on its control bus (address, write strobe, write data, all on the bus clock). From those writes it keeps its own copy of the programmed minimum packet spacing and of the transmit clock divisor. It also watches the transmitter's valid line.

The spacing is programmed in transmit-clock periods, and the transmit clock is the bus clock divided by the divisor, so the required idle time in bus cycles is `divisor * (delay + 1)`. When valid falls, a countdown of that length starts. If valid rises again before the countdown has expired, the `gap_ok` output drops for a single cycle. Any reprogramming of the spacing, of the divisor or of the command-set register while a countdown is running abandons that one check quietly, because the rule being enforced has just changed under it.

The monitor drives nothing back into the transmitter. Its only output is `gap_ok`, which a checker or an error collector samples.

Top module: `ipg_monitor`

## Requirements
- R1: After reset `gap_ok` is 1, no gap window is open, and the captured spacing is 0 and the divisor is 1. A reset during an open window discards it, so a rise of `tx_valid` after reset is never flagged.
- R2: A write (`bus_wr` = 1) to address 2 captures `bus_wdata[15:0]` as the spacing. A write to address 3 captures `bus_wdata[7:0]` as the divisor. Each value is held until its address is written again.
- R3: End of packet is the cycle in which `tx_valid` is 0 and was 1 in the cycle before. It opens a window of G = divisor * (spacing + 1) bus cycles, and the end-of-packet cycle counts as the first of them.
- R4: If `tx_valid` rises after exactly j low cycles (the end-of-packet cycle included) with j < G, then `gap_ok` is 0 for exactly one cycle: the cycle that follows the clock edge that samples the rise.
- R5: If `tx_valid` rises after j >= G low cycles, `gap_ok` stays 1.
- R6: A write to address 2, 3 or 0 (command-set) in any cycle from the end-of-packet cycle up to and including the cycle of the rise cancels the check for that gap. No flag is raised for it.
- R7: A write to address 1 (command-clear) or to any undecoded address during a window does not cancel the check.
- R8: When G is 0 or 1 (divisor 0, or divisor 1 with spacing 0), no rise is ever flagged.
- R9: The countdown holds the largest product of a 16-bit spacing and an 8-bit divisor without wrapping. With G = 65536, a rise after 65535 low cycles is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address of the snooped control bus |
| bus_wr | input | 1 | Write strobe of the snooped control bus |
| bus_wdata | input | 16 | Write data of the snooped control bus |
| tx_valid | input | 1 | Valid line of the watched transmitter |
| gap_ok | output | 1 | 0 for one cycle after a packet starts too early, 1 otherwise |

## Verification
The bench sweeps every spacing from 0 to 2 against every divisor from 0 to 3. For each pair it tries every idle length from one cycle up to one past the required gap, which separates the last flagged length (G-1) from the first accepted one (G) and exposes any off-by-one in the product or in the count. For the longer gaps, reconfiguration writes land in the end-of-packet cycle, in mid-window and in the cycle of the rise, to each decoded address and to an undecoded one. This shows which addresses cancel the check and up to which cycle a cancellation still takes effect. A single window of 65536 cycles distinguishes a countdown that is wide enough from one that wraps at 16 bits, and a reset in mid-window shows that reset discards the open window.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

    // Decoded view of one snooped bus cycle.
    typedef struct packed {
        logic set_delay;   // spacing register written
        logic set_div;     // divisor register written
        logic cancel;      // write that invalidates an open gap window
    } bus_hit_t;

endpackage

// File: rtl/ipg_cfg_snoop.sv
module ipg_cfg_snoop
    import ipg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int DELAY_W  = 16,
    parameter int DIV_W    = 8,
    parameter logic [ADDR_W-1:0] A_SET   = 4'h0,
    parameter logic [ADDR_W-1:0] A_CLR   = 4'h1,
    parameter logic [ADDR_W-1:0] A_DELAY = 4'h2,
    parameter logic [ADDR_W-1:0] A_CLK   = 4'h3,
    localparam int CNT_W = DELAY_W + 1 + DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DELAY_W-1:0] delay_q,
    output logic [DIV_W-1:0]  div_q,
    output logic [CNT_W-1:0]  gap_len,
    output bus_hit_t          hit
);

    typedef struct packed {
        logic [DELAY_W-1:0] delay;
        logic [DIV_W-1:0]   div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        // Command-clear never counts as reconfiguration, even if an
        // address parameter were set to collide with it.
        hit.set_delay = bus_wr && (bus_addr == A_DELAY) && (bus_addr != A_CLR);
        hit.set_div   = bus_wr && (bus_addr == A_CLK)   && (bus_addr != A_CLR);
        hit.cancel    = hit.set_delay || hit.set_div ||
                        (bus_wr && (bus_addr == A_SET) && (bus_addr != A_CLR));

        cfg_d = cfg_q;
        if (hit.set_delay) cfg_d.delay = bus_wdata[DELAY_W-1:0];
        if (hit.set_div)   cfg_d.div   = bus_wdata[DIV_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.delay <= '0;
            cfg_q.div   <= DIV_W'(1);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign delay_q = cfg_q.delay;
    assign div_q   = cfg_q.div;
    assign gap_len = CNT_W'(cfg_q.div) * (CNT_W'(cfg_q.delay) + CNT_W'(1));

endmodule

// File: rtl/ipg_gap_timer.sv
module ipg_gap_timer #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_valid,
    input  logic             cancel,
    input  logic [CNT_W-1:0] gap_len,
    output logic [CNT_W-1:0] gap_cnt,
    output logic             gap_ok
);

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic             ok;
    } tmr_t;

    tmr_t s_d, s_q;
    logic eop, rise;

    always_comb begin
        eop  = s_q.valid && !tx_valid;
        rise = !s_q.valid && tx_valid;

        s_d       = s_q;
        s_d.valid = tx_valid;
        s_d.ok    = 1'b1;

        if (cancel) begin
            s_d.cnt = '0;
        end else if (eop) begin
            // the end-of-packet cycle is the first idle cycle
            s_d.cnt = (gap_len == '0) ? '0 : gap_len - CNT_W'(1);
        end else if (rise) begin
            s_d.ok  = (s_q.cnt == '0);
            s_d.cnt = '0;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.valid <= 1'b0;
            s_q.cnt   <= '0;
            s_q.ok    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign gap_cnt = s_q.cnt;
    assign gap_ok  = s_q.ok;

endmodule

// File: rtl/ipg_monitor.sv
module ipg_monitor
    import ipg_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int DELAY_W  = 16,
    parameter int DIV_W    = 8,
    parameter logic [ADDR_W-1:0] A_SET   = 4'h0,
    parameter logic [ADDR_W-1:0] A_CLR   = 4'h1,
    parameter logic [ADDR_W-1:0] A_DELAY = 4'h2,
    parameter logic [ADDR_W-1:0] A_CLK   = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tx_valid,
    output logic              gap_ok
);

    localparam int CNT_W = DELAY_W + 1 + DIV_W;

    bus_hit_t           hit;
    logic [DELAY_W-1:0] cfg_delay;
    logic [DIV_W-1:0]   cfg_div;
    logic [CNT_W-1:0]   gap_len;
    logic [CNT_W-1:0]   gap_cnt;

    ipg_cfg_snoop #(
        .ADDR_W (ADDR_W),  .DATA_W (DATA_W),
        .DELAY_W(DELAY_W), .DIV_W  (DIV_W),
        .A_SET  (A_SET),   .A_CLR  (A_CLR),
        .A_DELAY(A_DELAY), .A_CLK  (A_CLK)
    ) u_snoop (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .delay_q  (cfg_delay),
        .div_q    (cfg_div),
        .gap_len  (gap_len),
        .hit      (hit)
    );

    ipg_gap_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_valid(tx_valid),
        .cancel  (hit.cancel),
        .gap_len (gap_len),
        .gap_cnt (gap_cnt),
        .gap_ok  (gap_ok)
    );

endmodule

// File: rtl/ipg_monitor_sva.sv
module ipg_monitor_sva #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16,
    parameter int DELAY_W  = 16,
    parameter int DIV_W    = 8,
    parameter logic [ADDR_W-1:0] A_SET   = 4'h0,
    parameter logic [ADDR_W-1:0] A_CLR   = 4'h1,
    parameter logic [ADDR_W-1:0] A_DELAY = 4'h2,
    parameter logic [ADDR_W-1:0] A_CLK   = 4'h3,
    localparam int CNT_W = DELAY_W + 1 + DIV_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               tx_valid,
    input logic               gap_ok,
    input logic [DELAY_W-1:0] cfg_delay,
    input logic [DIV_W-1:0]   cfg_div,
    input logic [CNT_W-1:0]   gap_cnt
);

    logic wr_cancel;
    assign wr_cancel = bus_wr && (bus_addr != A_CLR) &&
                       (bus_addr == A_SET || bus_addr == A_DELAY || bus_addr == A_CLK);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> gap_ok && gap_cnt == '0);

    p_take_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_DELAY && bus_addr != A_CLR
        |=> cfg_delay == $past(bus_wdata[DELAY_W-1:0]));

    p_take_div_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_CLK && bus_addr != A_CLR
        |=> cfg_div == $past(bus_wdata[DIV_W-1:0]));

    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt != '0 && !tx_valid && !wr_cancel
        |=> gap_cnt == $past(gap_cnt) - CNT_W'(1));

    p_flag_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_ok |=> gap_ok);

    p_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !gap_ok |-> $past(tx_valid) && !$past(tx_valid, 2));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt == '0 |=> gap_ok);

    p_cancel_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cancel |=> gap_ok && gap_cnt == '0);

endmodule

bind ipg_monitor ipg_monitor_sva #(
    .ADDR_W (ADDR_W),  .DATA_W (DATA_W),
    .DELAY_W(DELAY_W), .DIV_W  (DIV_W),
    .A_SET  (A_SET),   .A_CLR  (A_CLR),
    .A_DELAY(A_DELAY), .A_CLK  (A_CLK)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .tx_valid (tx_valid),
    .gap_ok   (gap_ok),
    .cfg_delay(cfg_delay),
    .cfg_div  (cfg_div),
    .gap_cnt  (gap_cnt)
);

// File: tb/ipg_monitor_tb_top.sv
module ipg_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] AD_SET = 4'h0, AD_CLR = 4'h1,
                           AD_DLY = 4'h2, AD_CLK = 4'h3, AD_IDLE = 4'hF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = AD_IDLE;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        tx_valid = 1'b0;
    logic        gap_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipg_monitor dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .tx_valid (tx_valid),
        .gap_ok   (gap_ok)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic drive_wr(input logic [3:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
    endtask

    task automatic release_bus();
        bus_wr   = 1'b0;
        bus_addr = AD_IDLE;
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        drive_wr(a, d);
        @(negedge clk);
        release_bus();
    endtask

    // One packet, j idle cycles, then a new packet. Optional write at idle
    // step k (k == j means the cycle of the rise).
    task automatic run_gap(input int dly, input int dv, input int j,
                           input bit ab_en, input int ab_k, input logic [3:0] ab_a,
                           input string req);
        int g;
        bit cancel;
        logic [15:0] ab_d;
        g      = dv * (dly + 1);
        cancel = ab_en && (ab_a == AD_SET || ab_a == AD_DLY || ab_a == AD_CLK) && ab_k <= j;
        ab_d   = (ab_a == AD_DLY) ? 16'(dly) : (ab_a == AD_CLK) ? 16'(dv) : 16'hA5A5;
        bus_write(AD_DLY, 16'(dly));
        bus_write(AD_CLK, 16'(dv));
        tx_valid = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < j; i++) begin
            tx_valid = 1'b0;
            if (ab_en && i == ab_k) drive_wr(ab_a, ab_d); else release_bus();
            @(negedge clk);
        end
        tx_valid = 1'b1;
        if (ab_en && ab_k == j) drive_wr(ab_a, ab_d); else release_bus();
        @(negedge clk);
        release_bus();
        check(req, int'(gap_ok), ((j < g) && !cancel) ? 0 : 1);
        @(negedge clk);
        check("R4 flag lasts one cycle", int'(gap_ok), 1);
        // close the packet with a cancelling write so no window stays open
        tx_valid = 1'b0;
        bus_write(AD_SET, 16'h0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 gap_ok after reset", int'(gap_ok), 1);

        // R1: first rise after reset, no window open
        tx_valid = 1'b1;
        @(negedge clk);
        check("R1 no window after reset", int'(gap_ok), 1);
        @(negedge clk);
        // R1: reset values give G = 1, a single idle cycle is accepted
        tx_valid = 1'b0;
        @(negedge clk);
        tx_valid = 1'b1;
        @(negedge clk);
        check("R1 reset spacing and divisor", int'(gap_ok), 1);
        tx_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);

        // R1: reset in mid-window discards it
        bus_write(AD_DLY, 16'd5);
        bus_write(AD_CLK, 16'd2);
        tx_valid = 1'b1;
        repeat (2) @(negedge clk);
        tx_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tx_valid = 1'b1;
        @(negedge clk);
        check("R1 reset discards window", int'(gap_ok), 1);
        tx_valid = 1'b0;
        bus_write(AD_SET, 16'h0);

        // R2 R3 R4 R5 R8: sweep spacing, divisor and idle length
        for (int dly = 0; dly < 3; dly++) begin
            for (int dv = 0; dv < 4; dv++) begin
                int g;
                int jmax;
                g    = dv * (dly + 1);
                jmax = (g + 1 < 2) ? 2 : g + 1;
                for (int j = 1; j <= jmax; j++) begin
                    if (g <= 1)      run_gap(dly, dv, j, 1'b0, 0, AD_IDLE, "R8 short gap never flagged");
                    else if (j < g)  run_gap(dly, dv, j, 1'b0, 0, AD_IDLE, "R4 early packet flagged");
                    else             run_gap(dly, dv, j, 1'b0, 0, AD_IDLE, "R5 full gap accepted");
                end
            end
        end

        // R6 R7: writes during the window
        for (int dly = 1; dly < 3; dly++) begin
            for (int dv = 2; dv < 4; dv++) begin
                int j;
                j = dv * (dly + 1) - 1;
                for (int p = 0; p < 3; p++) begin
                    int k;
                    k = (p == 0) ? 0 : (p == 1) ? j / 2 : j;
                    run_gap(dly, dv, j, 1'b1, k, AD_SET, "R6 command-set cancels");
                    run_gap(dly, dv, j, 1'b1, k, AD_DLY, "R6 spacing write cancels");
                    run_gap(dly, dv, j, 1'b1, k, AD_CLK, "R6 divisor write cancels");
                    run_gap(dly, dv, j, 1'b1, k, AD_CLR, "R7 command-clear ignored");
                    run_gap(dly, dv, j, 1'b1, k, 4'h9,   "R7 undecoded write ignored");
                end
            end
        end

        // R2 R9: G = 32 * 2048 = 65536, needs more than 16 counter bits
        run_gap(2047, 32, 65535, 1'b0, 0, AD_IDLE, "R9 wide gap flagged");

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule